// File: doc/BRIEF.md
# Shared and Private Interrupt Distributor

This block gathers interrupt lines from devices and from the CPU-side logic and keeps, for each interrupt ID, an enable bit, a pending bit, an active bit and a trigger type. Every interrupt that is enabled and pending, and not yet active, is offered to one or more CPU interfaces. The result is a flat vector with one bit per interrupt for each CPU interface. Arbitration between the offered IDs is left to the CPU interfaces. Each CPU interface takes an interrupt with an acknowledge strobe and releases it with an end-of-interrupt strobe.

IDs 0 to 31 are private: each CPU interface has its own copy of their enable, pending and active bits. IDs 0 to 15 are software-generated and always rising-edge. IDs from 32 up to `N_IRQ-1` are shared. Each shared ID has a 16-bit routing field with one bit per CPU interface. Software programs the block through a word-addressed register port with read and write strobes. `bus_cpu` tells the block which CPU interface is making the access, which selects the private bank. Read data appears on `reg_rdata` one cycle after the read strobe and holds until the next read. `N_IRQ` must lie between 33 and 510.

Top module: `irq_distributor`

## Requirements
- R1: Bit 0 of the control word (word address 0x000) gates forwarding. While it is 0, every bit of `fwd` is 0 and pending state is still kept. Writing 1 lets pending, enabled interrupts forward again.
- R2: The read-only word at address 0x001 returns ceil(N_IRQ/32)-1 in bits [4:0] and 0 in all other bits.
- R3: Interrupt n is enabled by writing 1 to bit n%32 of word 0x020+n/32 and disabled by writing 1 to the same bit of word 0x030+n/32. Writing 0 to a bit leaves its interrupt unchanged. Reading either word returns the current enable bits.
- R4: The routing field of shared interrupt n is bits [(n%2)*16 +: 16] of word 0x100+n/2, and bit c of that field sends the interrupt to CPU interface c. The field reads back as written.
- R5: A read of any routing word 0x100 to 0x10F returns the reader's one-hot code (1 << bus_cpu) in both halves. Writes to these words are ignored.
- R6: The enable, pending and active bits of IDs 0 to 31 are separate for each CPU interface. Enable accesses go to the bank selected by `bus_cpu`, and acknowledging a private ID on one interface does not affect any other interface.
- R7: The trigger code of ID n is 2 bits, at bits [(n%16)*2 +: 2] of word 0x040+n/16. The codes are: 00 level high, 01 level low, 10 rising edge, 11 falling edge. Word 0x040 always reads 0xAAAAAAAA and writes to it are ignored. IDs 16 to 31 accept all four codes.
- R8: A shared ID accepts only code 00 or 10. If a write carries code 01 or 11 for a shared ID, that ID's field keeps its old value, while the other fields in the same word still update.
- R9: An edge-triggered interrupt becomes pending on the selected edge of its line. It stays pending after the line returns, until it is acknowledged.
- R10: A level-triggered interrupt is pending whenever its line is at the asserted level and the interrupt is not active. An acknowledge makes the interrupt active and removes it from `fwd` on the next cycle. An end-of-interrupt makes it inactive again.
- R11: Bits and fields that belong to IDs at or above N_IRQ read as 0, and writes to them have no effect.
- R12: After reset, the control word, all enables, all pending and active bits and all of `fwd` are 0, and routing fields and shared trigger codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cpu | input | max(1,clog2(N_CPU)) | Index of the CPU interface making the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| shared_in | input | N_IRQ-32 | Lines of shared IDs; bit i is ID 32+i |
| priv_in | input | N_CPU*32 | Private lines; bit c*32+b is ID b of CPU interface c |
| ack_valid | input | N_CPU | Acknowledge strobe for each CPU interface |
| ack_id | input | N_CPU*9 | Acknowledged ID for each CPU interface |
| eoi_valid | input | N_CPU | End-of-interrupt strobe for each CPU interface |
| eoi_id | input | N_CPU*9 | Completed ID for each CPU interface |
| fwd | output | N_CPU*N_IRQ | Bit c*N_IRQ+n: ID n is offered to CPU interface c |

## Verification
The properties assume that all inputs are synchronous to `clk` and change only between edges. They also assume that a CPU interface acknowledges an ID only while that ID is offered to it, and sends an end-of-interrupt only for an ID it has acknowledged. The bench changes inputs one time unit after the rising edge and compares at the falling edge. Its acknowledges target IDs it has just seen forwarded, and each end-of-interrupt matches an earlier acknowledge. Register reads and writes are never issued in the same cycle. `bus_cpu` stays steady from the strobe until the edge that captures it.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int MAX_IRQ  = 510;
    localparam int PRIV_N   = 32;
    localparam int SGI_N    = 16;
    localparam int ID_W     = 9;
    localparam int AW       = 10;

    localparam logic [AW-1:0] A_CTRL  = 10'h000;
    localparam logic [AW-1:0] A_LINES = 10'h001;
    localparam logic [AW-1:0] A_ENSET = 10'h020;
    localparam logic [AW-1:0] A_ENCLR = 10'h030;
    localparam logic [AW-1:0] A_CFG   = 10'h040;
    localparam logic [AW-1:0] A_TGT   = 10'h100;

    typedef enum logic [1:0] {
        TRIG_LVL_HI    = 2'b00,
        TRIG_LVL_LO    = 2'b01,
        TRIG_EDGE_RISE = 2'b10,
        TRIG_EDGE_FALL = 2'b11
    } trig_e;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [AW-1:0] addr;
        logic [31:0]   wdata;
    } reg_req_t;

    function automatic int idx_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int word_count(int n);
        return (n + 31) / 32;
    endfunction

endpackage

// File: rtl/irqd_src.sv
module irqd_src (
    input  logic       clk,
    input  logic       rst,
    input  logic       line,
    input  logic [1:0] trig,
    input  logic       take,
    input  logic       done,
    output logic       pend,
    output logic       act
);

    logic prev_q;
    logic lvl_on;
    logic edge_hit;
    logic act_nx;

    always_comb begin
        lvl_on   = trig[0] ? ~line : line;
        edge_hit = trig[0] ? (prev_q & ~line) : (~prev_q & line);
        act_nx   = take | (act & ~done);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
            act    <= 1'b0;
        end else begin
            prev_q <= line;
            act    <= act_nx;
            if (trig[1]) begin
                pend <= edge_hit | (pend & ~take);
            end else begin
                pend <= act_nx ? 1'b0 : lvl_on;
            end
        end
    end

endmodule

// File: rtl/irqd_regs.sv
module irqd_regs
    import irqd_pkg::*;
#(
    parameter int N_IRQ = 80,
    parameter int N_CPU = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  reg_req_t                        req,
    input  logic [idx_w(N_CPU)-1:0]         bus_cpu,
    output logic                            glb_en,
    output logic [N_IRQ-PRIV_N-1:0]         en_sh,
    output logic [N_CPU-1:0][PRIV_N-1:0]    en_pv,
    output logic [N_IRQ-PRIV_N-1:0]         cfg_sh,
    output logic [SGI_N-1:0][1:0]           cfg_pp,
    output logic [N_IRQ-PRIV_N-1:0][N_CPU-1:0] tgt_lo,
    output logic [31:0]                     rdata
);

    localparam int N_SH    = N_IRQ - PRIV_N;
    localparam int N_WORDS = word_count(N_IRQ);
    localparam int CPU_W   = idx_w(N_CPU);

    logic [N_SH-1:0][15:0] tgt_sh;
    logic [31:0]           rd_val;
    logic                  wr_ctrl;

    assign wr_ctrl = req.wr && (req.addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en <= 1'b0;
            en_sh  <= '0;
            en_pv  <= '0;
            cfg_sh <= '0;
            cfg_pp <= '0;
            tgt_sh <= '0;
        end else begin
            if (wr_ctrl) begin
                glb_en <= req.wdata[0];
            end
            for (int i = 0; i < N_SH; i++) begin
                if (req.wr && req.addr == A_ENSET + AW'((i + PRIV_N) / 32)
                    && req.wdata[(i + PRIV_N) % 32]) begin
                    en_sh[i] <= 1'b1;
                end
                if (req.wr && req.addr == A_ENCLR + AW'((i + PRIV_N) / 32)
                    && req.wdata[(i + PRIV_N) % 32]) begin
                    en_sh[i] <= 1'b0;
                end
                if (req.wr && req.addr == A_CFG + AW'((i + PRIV_N) / 16)
                    && !req.wdata[((i + PRIV_N) % 16) * 2]) begin
                    cfg_sh[i] <= req.wdata[((i + PRIV_N) % 16) * 2 + 1];
                end
                if (req.wr && req.addr == A_TGT + AW'((i + PRIV_N) / 2)) begin
                    tgt_sh[i] <= req.wdata[((i + PRIV_N) % 2) * 16 +: 16];
                end
            end
            for (int c = 0; c < N_CPU; c++) begin
                for (int b = 0; b < PRIV_N; b++) begin
                    if (req.wr && bus_cpu == CPU_W'(c) && req.addr == A_ENSET
                        && req.wdata[b]) begin
                        en_pv[c][b] <= 1'b1;
                    end
                    if (req.wr && bus_cpu == CPU_W'(c) && req.addr == A_ENCLR
                        && req.wdata[b]) begin
                        en_pv[c][b] <= 1'b0;
                    end
                end
            end
            if (req.wr && req.addr == A_CFG + AW'(1)) begin
                for (int b = 0; b < SGI_N; b++) begin
                    cfg_pp[b] <= req.wdata[b*2 +: 2];
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N_SH; i++) begin
            tgt_lo[i] = tgt_sh[i][N_CPU-1:0];
        end
    end

    always_comb begin
        rd_val = '0;
        if (req.addr == A_CTRL) begin
            rd_val[0] = glb_en;
        end
        if (req.addr == A_LINES) begin
            rd_val[4:0] = 5'(N_WORDS - 1);
        end
        for (int c = 0; c < N_CPU; c++) begin
            if (bus_cpu == CPU_W'(c)
                && (req.addr == A_ENSET || req.addr == A_ENCLR)) begin
                rd_val = en_pv[c];
            end
            if (bus_cpu == CPU_W'(c)
                && req.addr >= A_TGT && req.addr < A_TGT + AW'(PRIV_N / 2)) begin
                rd_val = {2{16'(1) << c}};
            end
        end
        if (req.addr == A_CFG) begin
            rd_val = {SGI_N{TRIG_EDGE_RISE}};
        end
        if (req.addr == A_CFG + AW'(1)) begin
            for (int b = 0; b < SGI_N; b++) begin
                rd_val[b*2 +: 2] = cfg_pp[b];
            end
        end
        for (int i = 0; i < N_SH; i++) begin
            if (req.addr == A_ENSET + AW'((i + PRIV_N) / 32)
                || req.addr == A_ENCLR + AW'((i + PRIV_N) / 32)) begin
                rd_val[(i + PRIV_N) % 32] = en_sh[i];
            end
            if (req.addr == A_CFG + AW'((i + PRIV_N) / 16)) begin
                rd_val[((i + PRIV_N) % 16) * 2 + 1] = cfg_sh[i];
            end
            if (req.addr == A_TGT + AW'((i + PRIV_N) / 2)) begin
                rd_val[((i + PRIV_N) % 2) * 16 +: 16] = tgt_sh[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (req.rd) begin
            rdata <= rd_val;
        end
    end

endmodule

// File: rtl/irqd_route.sv
module irqd_route
    import irqd_pkg::*;
#(
    parameter int N_IRQ = 80,
    parameter int N_CPU = 2
) (
    input  logic                               glb_en,
    input  logic [N_IRQ-PRIV_N-1:0]            en_sh,
    input  logic [N_IRQ-PRIV_N-1:0]            pend_sh,
    input  logic [N_IRQ-PRIV_N-1:0]            act_sh,
    input  logic [N_IRQ-PRIV_N-1:0][N_CPU-1:0] tgt_lo,
    input  logic [N_CPU-1:0][PRIV_N-1:0]       en_pv,
    input  logic [N_CPU-1:0][PRIV_N-1:0]       pend_pv,
    input  logic [N_CPU-1:0][PRIV_N-1:0]       act_pv,
    output logic [N_CPU-1:0][N_IRQ-1:0]        fwd2d
);

    localparam int N_SH = N_IRQ - PRIV_N;

    always_comb begin
        for (int c = 0; c < N_CPU; c++) begin
            for (int b = 0; b < PRIV_N; b++) begin
                fwd2d[c][b] = glb_en & en_pv[c][b] & pend_pv[c][b] & ~act_pv[c][b];
            end
            for (int i = 0; i < N_SH; i++) begin
                fwd2d[c][i+PRIV_N] = glb_en & en_sh[i] & pend_sh[i]
                                   & ~act_sh[i] & tgt_lo[i][c];
            end
        end
    end

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int N_IRQ = 80,
    parameter int N_CPU = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [idx_w(N_CPU)-1:0]     bus_cpu,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [AW-1:0]               reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    input  logic [N_IRQ-PRIV_N-1:0]     shared_in,
    input  logic [N_CPU*PRIV_N-1:0]     priv_in,
    input  logic [N_CPU-1:0]            ack_valid,
    input  logic [N_CPU*ID_W-1:0]       ack_id,
    input  logic [N_CPU-1:0]            eoi_valid,
    input  logic [N_CPU*ID_W-1:0]       eoi_id,
    output logic [N_CPU*N_IRQ-1:0]      fwd
);

    localparam int N_SH = N_IRQ - PRIV_N;

    reg_req_t                        req;
    logic                            glb_en;
    logic [N_SH-1:0]                 en_sh, cfg_sh, pend_sh, act_sh, take_sh, done_sh;
    logic [N_SH-1:0][N_CPU-1:0]      tgt_lo;
    logic [SGI_N-1:0][1:0]           cfg_pp;
    logic [N_CPU-1:0][PRIV_N-1:0]    en_pv, pend_pv, act_pv, take_pv, done_pv;
    logic [N_CPU-1:0][N_IRQ-1:0]     fwd2d;

    assign req = '{wr: reg_wr, rd: reg_rd, addr: reg_addr, wdata: reg_wdata};
    assign fwd = fwd2d;

    irqd_regs #(.N_IRQ(N_IRQ), .N_CPU(N_CPU)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .bus_cpu(bus_cpu),
        .glb_en (glb_en),
        .en_sh  (en_sh),
        .en_pv  (en_pv),
        .cfg_sh (cfg_sh),
        .cfg_pp (cfg_pp),
        .tgt_lo (tgt_lo),
        .rdata  (reg_rdata)
    );

    always_comb begin
        take_sh = '0;
        done_sh = '0;
        take_pv = '0;
        done_pv = '0;
        for (int c = 0; c < N_CPU; c++) begin
            for (int i = 0; i < N_SH; i++) begin
                if (ack_valid[c] && ack_id[c*ID_W +: ID_W] == ID_W'(i + PRIV_N)
                    && fwd2d[c][i+PRIV_N]) begin
                    take_sh[i] = 1'b1;
                end
                if (eoi_valid[c] && eoi_id[c*ID_W +: ID_W] == ID_W'(i + PRIV_N)) begin
                    done_sh[i] = 1'b1;
                end
            end
            for (int b = 0; b < PRIV_N; b++) begin
                take_pv[c][b] = ack_valid[c] && ack_id[c*ID_W +: ID_W] == ID_W'(b)
                                && fwd2d[c][b];
                done_pv[c][b] = eoi_valid[c] && eoi_id[c*ID_W +: ID_W] == ID_W'(b);
            end
        end
    end

    for (genvar i = 0; i < N_SH; i++) begin : g_sh
        irqd_src u_src (
            .clk (clk),
            .rst (rst),
            .line(shared_in[i]),
            .trig({cfg_sh[i], 1'b0}),
            .take(take_sh[i]),
            .done(done_sh[i]),
            .pend(pend_sh[i]),
            .act (act_sh[i])
        );
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        for (genvar b = 0; b < PRIV_N; b++) begin : g_pv
            if (b < SGI_N) begin : g_sgi
                irqd_src u_src (
                    .clk (clk),
                    .rst (rst),
                    .line(priv_in[c*PRIV_N + b]),
                    .trig(TRIG_EDGE_RISE),
                    .take(take_pv[c][b]),
                    .done(done_pv[c][b]),
                    .pend(pend_pv[c][b]),
                    .act (act_pv[c][b])
                );
            end else begin : g_ppi
                irqd_src u_src (
                    .clk (clk),
                    .rst (rst),
                    .line(priv_in[c*PRIV_N + b]),
                    .trig(cfg_pp[b-SGI_N]),
                    .take(take_pv[c][b]),
                    .done(done_pv[c][b]),
                    .pend(pend_pv[c][b]),
                    .act (act_pv[c][b])
                );
            end
        end
    end

    irqd_route #(.N_IRQ(N_IRQ), .N_CPU(N_CPU)) u_route (
        .glb_en (glb_en),
        .en_sh  (en_sh),
        .pend_sh(pend_sh),
        .act_sh (act_sh),
        .tgt_lo (tgt_lo),
        .en_pv  (en_pv),
        .pend_pv(pend_pv),
        .act_pv (act_pv),
        .fwd2d  (fwd2d)
    );

endmodule

// File: rtl/irqd_chk.sv
module irqd_chk
    import irqd_pkg::*;
#(
    parameter int N_IRQ = 80,
    parameter int N_CPU = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   reg_rd,
    input logic [AW-1:0]          reg_addr,
    input logic [31:0]            reg_rdata,
    input logic                   glb_en,
    input logic [N_CPU*N_IRQ-1:0] fwd,
    input logic [N_CPU-1:0]       ack_valid,
    input logic [N_CPU*ID_W-1:0]  ack_id
);

    localparam int N_WORDS = word_count(N_IRQ);

    // R1
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> fwd == '0);

    // R2
    line_count_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_LINES) |=> reg_rdata == 32'(N_WORDS - 1));

    // R7
    sgi_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_CFG) |=> reg_rdata == 32'hAAAA_AAAA);

    // R5
    priv_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr >= A_TGT && reg_addr < A_TGT + AW'(16))
        |=> (reg_rdata[15:0] == reg_rdata[31:16] && $countones(reg_rdata[15:0]) == 1));

    // R11
    unimpl_en_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr >= A_ENSET + AW'(N_WORDS) && reg_addr < A_ENCLR)
        |=> reg_rdata == 32'h0);

    for (genvar c = 0; c < N_CPU; c++) begin : g_ack
        logic [ID_W-1:0] aid;
        assign aid = ack_id[c*ID_W +: ID_W];
        // R10
        ack_masks_chk: assert property (@(posedge clk) disable iff (rst)
            (ack_valid[c] && int'(aid) < N_IRQ && fwd[c*N_IRQ + int'(aid)])
            |=> !fwd[c*N_IRQ + int'($past(aid))]);
    end

endmodule

bind irq_distributor irqd_chk #(.N_IRQ(N_IRQ), .N_CPU(N_CPU)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .glb_en   (glb_en),
    .fwd      (fwd),
    .ack_valid(ack_valid),
    .ack_id   (ack_id)
);

// File: tb/irq_distributor_tb.sv
`timescale 1ns/1ps
module irq_distributor_tb;

    localparam int N  = 80;
    localparam int NC = 2;
    localparam int IW = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [0:0]        bus_cpu = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [9:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [N-33:0]     shared_in = '0;
    logic [NC*32-1:0]  priv_in = '0;
    logic [NC-1:0]     ack_valid = '0;
    logic [NC*IW-1:0]  ack_id = '0;
    logic [NC-1:0]     eoi_valid = '0;
    logic [NC*IW-1:0]  eoi_id = '0;
    logic [NC*N-1:0]   fwd;

    int checks = 0;
    int errors = 0;
    logic [31:0] sb_exp[$];
    string       sb_tag[$];
    logic        rd_seen = 1'b0;

    irq_distributor #(.N_IRQ(N), .N_CPU(NC)) u_dut (
        .clk(clk), .rst(rst), .bus_cpu(bus_cpu), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .shared_in(shared_in), .priv_in(priv_in), .ack_valid(ack_valid),
        .ack_id(ack_id), .eoi_valid(eoi_valid), .eoi_id(eoi_id), .fwd(fwd)
    );

    always #2.5 clk = ~clk;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, logic [31:0] exp, string tag);
        sb_exp.push_back(exp);
        sb_tag.push_back(tag);
        reg_rd = 1'b1; reg_addr = a;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic ack(int c, int id);
        ack_valid[c] = 1'b1; ack_id[c*IW +: IW] = IW'(id);
        tick();
        ack_valid[c] = 1'b0;
    endtask

    task automatic eoi(int c, int id);
        eoi_valid[c] = 1'b1; eoi_id[c*IW +: IW] = IW'(id);
        tick();
        eoi_valid[c] = 1'b0;
    endtask

    task automatic fchk(string tag, int c, int id, logic e);
        check(tag, 32'(fwd[c*N + id]), 32'(e));
    endtask

    always @(posedge clk) rd_seen <= reg_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_exp.size() == 0) begin
                check("scoreboard underflow", 32'h1, 32'h0);
            end else begin
                check(sb_tag.pop_front(), reg_rdata, sb_exp.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R12 reset state
        check("R12 fwd after reset", 32'(fwd == '0), 32'h1);
        rd(10'h000, 32'h0, "R12 control after reset");
        rd(10'h021, 32'h0, "R12 enables after reset");
        // R2 line count
        rd(10'h001, 32'h2, "R2 line count");
        // R7 software-generated trigger codes fixed
        rd(10'h040, 32'hAAAA_AAAA, "R7 sgi cfg read");
        wr(10'h040, 32'h0);
        rd(10'h040, 32'hAAAA_AAAA, "R7 sgi cfg write ignored");
        // R5 private routing words
        bus_cpu = 1'b1;
        rd(10'h100, 32'h0002_0002, "R5 private tgt cpu1");
        wr(10'h100, 32'h0);
        rd(10'h107, 32'h0002_0002, "R5 private tgt write ignored");
        bus_cpu = 1'b0;
        rd(10'h100, 32'h0001_0001, "R5 private tgt cpu0");
        // R4 shared routing field layout
        wr(10'h114, 32'h0002_0001);
        rd(10'h114, 32'h0002_0001, "R4 tgt readback");
        // R3 enable set
        wr(10'h021, 32'h0000_0300);
        rd(10'h021, 32'h0000_0300, "R3 enable set readback");
        wr(10'h000, 32'h1);
        shared_in[8] = 1'b1;
        tick();
        fchk("R4 id40 to cpu0", 0, 40, 1'b1);
        fchk("R4 id40 not cpu1", 1, 40, 1'b0);
        shared_in[9] = 1'b1;
        tick();
        fchk("R4 id41 to cpu1", 1, 41, 1'b1);
        fchk("R4 id41 not cpu0", 0, 41, 1'b0);
        // R1 global gate
        wr(10'h000, 32'h0);
        fchk("R1 gate off", 0, 40, 1'b0);
        rd(10'h000, 32'h0, "R1 control reads 0");
        wr(10'h000, 32'h1);
        fchk("R1 gate on again", 0, 40, 1'b1);
        // R10 level: ack masks, eoi re-arms
        ack(0, 40);
        fchk("R10 masked after ack", 0, 40, 1'b0);
        tick();
        fchk("R10 stays masked while active", 0, 40, 1'b0);
        eoi(0, 40);
        fchk("R10 pending again after eoi", 0, 40, 1'b1);
        shared_in[8] = 1'b0;
        tick();
        fchk("R10 level drop clears pending", 0, 40, 1'b0);
        // R3 enable clear
        wr(10'h031, 32'h0000_0200);
        fchk("R3 cleared id41", 1, 41, 1'b0);
        rd(10'h021, 32'h0000_0100, "R3 clear readback");
        // R8 shared trigger codes: id50 rising edge, id51 level-low rejected
        wr(10'h043, 32'h0000_0060);
        rd(10'h043, 32'h0000_0020, "R8 shared cfg filter");
        wr(10'h119, 32'h0000_0002);
        wr(10'h021, 32'h0004_0000);
        // R9 edge pending latch
        shared_in[18] = 1'b1;
        tick();
        shared_in[18] = 1'b0;
        tick();
        fchk("R9 edge latched", 1, 50, 1'b1);
        tick(); tick();
        fchk("R9 edge held", 1, 50, 1'b1);
        ack(1, 50);
        fchk("R9 ack clears", 1, 50, 1'b0);
        eoi(1, 50);
        fchk("R9 no re-pend without edge", 1, 50, 1'b0);
        // R7 private trigger codes: id20 level low
        wr(10'h041, 32'h0000_0100);
        rd(10'h041, 32'h0000_0100, "R7 private cfg readback");
        // R6 banked enables
        wr(10'h020, 32'h0010_0000);
        tick();
        fchk("R6 cpu0 id20 forwarded", 0, 20, 1'b1);
        fchk("R6 cpu1 id20 not enabled", 1, 20, 1'b0);
        bus_cpu = 1'b1;
        rd(10'h020, 32'h0, "R6 cpu1 bank empty");
        wr(10'h020, 32'h0010_0008);
        tick();
        fchk("R6 cpu1 id20 forwarded", 1, 20, 1'b1);
        ack(1, 20);
        fchk("R6 cpu1 id20 active", 1, 20, 1'b0);
        fchk("R6 cpu0 id20 unaffected", 0, 20, 1'b1);
        bus_cpu = 1'b0;
        rd(10'h020, 32'h0010_0000, "R6 cpu0 bank");
        // R9 software-generated edge on cpu1
        priv_in[32+3] = 1'b1;
        tick();
        priv_in[32+3] = 1'b0;
        tick();
        fchk("R9 sgi cpu1 pending", 1, 3, 1'b1);
        fchk("R6 sgi cpu0 untouched", 0, 3, 1'b0);
        // R11 unimplemented IDs
        wr(10'h022, 32'h8000_0001);
        rd(10'h022, 32'h0000_0001, "R11 enable beyond N");
        wr(10'h12D, 32'hFFFF_FFFF);
        rd(10'h12D, 32'h0, "R11 tgt beyond N");
        wr(10'h127, 32'h0003_0001);
        rd(10'h127, 32'h0003_0001, "R4 last implemented tgt word");
        tick(); tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule